// File: doc/BRIEF.md
# Sixteen-Channel PWM Bank with Deferred Edge Commit

This block drives sixteen pulse-width-modulated outputs from one time base. A single prescaler divides the input clock, and a step counter runs from 0 up to a programmed last step, then wraps. Every channel has a turn-on step and a turn-off step. The channel output is high while the step counter lies between the two. A per-channel enable forces an idle output low.

Software programs the block through a byte-wide register port with one-cycle writes and registered reads. At build time a 16-bit mask decides which channels carry a deferred (shadow) stage. For a channel without the stage, an edge write reaches the waveform at the next clock, even in mid-period. For a channel with the stage, edge writes are held back. Software marks them ready by writing 1 to the commit-request register. All shadowed channels then switch together at the first period boundary after that request. Edge reads always return the values that are currently shaping the waveform.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0 and every output is low.
- R2: The prescale register (word address 0) and the last-step register (address 1) set the period to (last_step + 1) × (prescale + 1) clocks. Each step lasts prescale + 1 clocks.
- R3: Address 2 holds the enables of channels 0–7 and address 3 holds those of channels 8–15, at bit position channel mod 8. A channel whose enable bit is 0 drives a low output.
- R4: If the on-step is below the off-step, the output is high for the steps on ≤ s < off. If the on-step is above the off-step, the window wraps through step 0. Equal steps give a constant low output. On-step 0 with off-step last_step + 1 gives a constant high output.
- R5: Channel c has its on-step at address 16 + 2c and its off-step at address 17 + 2c. For a channel without the shadow stage, a written value drives the waveform from the next clock, and a read returns it at once.
- R6: For a shadowed channel, edge writes leave the output and the read-back values unchanged. The writes take effect at the first period end after bit 0 is written as 1 to address 4.
- R7: Edge writes that follow a commit request are not part of that commit. They wait for a later request and a later period end.
- R8: Address 4 reads 1 in bit 0 while a commit is pending. It reads 0 once the commit has happened at the period boundary.
- R9: Read data appears on rdata in the clock cycle after the one in which rd_en is sampled, for every address in the map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word address of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pwm_out | output | 16 | Channel outputs |

## Verification
The bench counts high cycles over one full period. The count does not depend on phase, so a misplaced compare, an off-by-one at the wrapping window or a missing 100% case changes the count. It synchronises to the period start through a reference channel. It then checks that a shadowed channel stays on its old waveform until the boundary after a request. A design that committed at once, or that never committed, would show the wrong count or the wrong read-back. A write made after the request is checked to stay pending. A design that sampled the shadow at the boundary instead of at the request would wrongly apply that write. The bench also confirms the enable bit mapping across both enable registers.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_PRESCALE  = 6'd0;
  localparam logic [ADDR_W-1:0] A_LAST_STEP = 6'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE0   = 6'd2;
  localparam logic [ADDR_W-1:0] A_COMMIT    = 6'd4;
  localparam logic [ADDR_W-1:0] A_EDGE_BASE = 6'd16;

  // High window of a channel for the current step; equal edges give low.
  function automatic logic in_window(input logic [DW-1:0] step,
                                     input logic [DW-1:0] on_s,
                                     input logic [DW-1:0] off_s);
    if (on_s < off_s)      return (step >= on_s) && (step < off_s);
    else if (on_s > off_s) return (step >= on_s) || (step < off_s);
    else                   return 1'b0;
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] prescale,
  input  logic [DW-1:0] last_step,
  output logic [DW-1:0] step,
  output logic          period_end
);
  logic [DW-1:0] pre_q, pre_d, step_q, step_d;
  logic          tick, wrap;

  always_comb begin
    tick       = (pre_q >= prescale);
    wrap       = (step_q >= last_step);
    period_end = tick & wrap;
    pre_d      = tick ? '0 : pre_q + 1'b1;
    step_d     = step_q;
    if (tick) step_d = wrap ? '0 : step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      step_q <= '0;
    end else begin
      pre_q  <= pre_d;
      step_q <= step_d;
    end
  end

  assign step = step_q;

  // R2: a period boundary restarts the step count
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> (step == '0));
  // R2: inside a period each prescaler tick advances by one step
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !period_end) |=> (step == $past(step) + 1'b1));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter bit SHADOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_on,
  input  logic          wr_off,
  input  logic [DW-1:0] wdata,
  input  logic          snap,
  input  logic          commit,
  input  logic [DW-1:0] step,
  input  logic          en,
  output logic [DW-1:0] act_on,
  output logic [DW-1:0] act_off,
  output logic          out
);
  logic [DW-1:0] on_q, off_q, on_d, off_d;

  generate
    if (SHADOW) begin : g_shadow
      logic [DW-1:0] sh_on_q, sh_off_q, st_on_q, st_off_q;
      logic [DW-1:0] sh_on_d, sh_off_d, st_on_d, st_off_d;

      always_comb begin
        sh_on_d  = wr_on  ? wdata : sh_on_q;
        sh_off_d = wr_off ? wdata : sh_off_q;
        st_on_d  = snap ? sh_on_q  : st_on_q;
        st_off_d = snap ? sh_off_q : st_off_q;
        on_d     = commit ? st_on_q  : on_q;
        off_d    = commit ? st_off_q : off_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_on_q  <= '0;
          sh_off_q <= '0;
          st_on_q  <= '0;
          st_off_q <= '0;
        end else begin
          sh_on_q  <= sh_on_d;
          sh_off_q <= sh_off_d;
          st_on_q  <= st_on_d;
          st_off_q <= st_off_d;
        end
      end

      // R6: active edges move only at a commit
      assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(on_q) && $stable(off_q)));
      // R7: the staged copy reflects the shadow as it was at the request
      assert_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (st_on_q == $past(sh_on_q)));
    end else begin : g_direct
      logic unused_ctl;
      assign unused_ctl = snap ^ commit;

      always_comb begin
        on_d  = wr_on  ? wdata : on_q;
        off_d = wr_off ? wdata : off_q;
      end

      // R5: a direct write drives the waveform from the next clock
      assert_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_on |=> (on_q == $past(wdata)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= '0;
      off_q <= '0;
    end else begin
      on_q  <= on_d;
      off_q <= off_d;
    end
  end

  assign act_on  = on_q;
  assign act_off = off_q;
  assign out     = en & in_window(step, on_q, off_q);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int unsigned     NCH         = 16,
  parameter logic [NCH-1:0]  SHADOW_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned CW  = $clog2(NCH);
  localparam int unsigned ENR = NCH / DW;

  logic [DW-1:0]     pre_q, pre_d, last_q, last_d, rd_q, rd_d;
  logic [NCH-1:0]    en_q, en_d, wr_on, wr_off;
  logic              pend_q, pend_d, snap, commit, period_end, is_edge;
  logic [ADDR_W-1:0] eoff;
  logic [CW-1:0]     ch_sel;
  logic [DW-1:0]     step;
  logic [DW-1:0]     act_on  [NCH];
  logic [DW-1:0]     act_off [NCH];

  always_comb begin
    eoff    = addr - A_EDGE_BASE;
    is_edge = (addr >= A_EDGE_BASE) && (eoff < ADDR_W'(2 * NCH));
    ch_sel  = eoff[CW:1];
    snap    = wr_en && (addr == A_COMMIT) && wdata[0];
    commit  = pend_q && period_end;
    pend_d  = snap ? 1'b1 : (period_end ? 1'b0 : pend_q);
    pre_d   = (wr_en && addr == A_PRESCALE)  ? wdata : pre_q;
    last_d  = (wr_en && addr == A_LAST_STEP) ? wdata : last_q;
    en_d    = en_q;
    for (int g = 0; g < ENR; g++)
      if (wr_en && addr == A_ENABLE0 + ADDR_W'(g)) en_d[g*DW +: DW] = wdata;
    for (int c = 0; c < NCH; c++) begin
      wr_on[c]  = wr_en && is_edge && (ch_sel == CW'(c)) && !eoff[0];
      wr_off[c] = wr_en && is_edge && (ch_sel == CW'(c)) &&  eoff[0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (rd_en) begin
      if (addr == A_PRESCALE)       rd_d = pre_q;
      else if (addr == A_LAST_STEP) rd_d = last_q;
      else if (addr == A_COMMIT)    rd_d = {{(DW-1){1'b0}}, pend_q};
      else if (is_edge)             rd_d = eoff[0] ? act_off[ch_sel] : act_on[ch_sel];
      for (int g = 0; g < ENR; g++)
        if (addr == A_ENABLE0 + ADDR_W'(g)) rd_d = en_q[g*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      last_q <= '0;
      en_q   <= '0;
      pend_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      pre_q  <= pre_d;
      last_q <= last_d;
      en_q   <= en_d;
      pend_q <= pend_d;
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;

  pwm_timebase u_tb (
    .clk(clk), .rst_n(rst_n), .prescale(pre_q), .last_step(last_q),
    .step(step), .period_end(period_end)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwm_chan #(.SHADOW(SHADOW_MASK[c])) u_ch (
        .clk(clk), .rst_n(rst_n), .wr_on(wr_on[c]), .wr_off(wr_off[c]),
        .wdata(wdata), .snap(snap), .commit(commit), .step(step), .en(en_q[c]),
        .act_on(act_on[c]), .act_off(act_off[c]), .out(pwm_out[c])
      );
    end
  endgenerate

  // R8: a request raises the pending flag
  assert_req_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> pend_q);
  // R8: a boundary with no new request clears the pending flag
  assert_commit_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && period_end && !snap) |=> !pend_q);
  // R3: disabled channels stay low
  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_d) == '0 |-> pwm_out == '0);
endmodule

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h00FF;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, rd_en;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic [15:0] pwm_out;
  int checks = 0, errors = 0;

  pwm_bank #(.NCH(16), .SHADOW_MASK(MASK)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic measure(input int ch, input int len, output int cnt);
    cnt = 0;
    repeat (len) begin @(negedge clk); cnt += int'(pwm_out[ch]); end
  endtask

  task automatic wait_start();
    @(posedge pwm_out[8]);
  endtask

  function automatic int exp_high(input int on_s, input int off_s, input int last, input int pre);
    int n = 0;
    for (int s = 0; s <= last; s++) begin
      if (on_s < off_s)      n += (s >= on_s && s < off_s) ? 1 : 0;
      else if (on_s > off_s) n += (s >= on_s || s < off_s) ? 1 : 0;
    end
    return n * (pre + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v, n, prev, cur;
    int cnt [16];
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 outputs", int'(pwm_out), 0);
    rd(6'd0, v);  check("R1 prescale", v, 0);
    rd(6'd1, v);  check("R1 last step", v, 0);
    rd(6'd3, v);  check("R1 enable hi", v, 0);
    rd(6'd4, v);  check("R1 commit", v, 0);
    rd(6'd22, v); check("R1 edge", v, 0);

    // R9/R5: configuration and reference channel 8 (direct)
    wr(6'd0, 8'd1); wr(6'd1, 8'd9);
    wr(6'd33, 8'd1); wr(6'd3, 8'h01);
    rd(6'd0, v);  check("R9 prescale readback", v, 1);
    rd(6'd1, v);  check("R9 last step readback", v, 9);
    rd(6'd33, v); check("R5 direct edge readback", v, 1);

    // R2: period length and step length
    wait_start(); measure(8, 20, n); check("R2 step length", n, 2);
    wait_start(); @(negedge clk); n = 1; prev = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); cur = int'(pwm_out[8]);
      if (cur == 1 && prev == 0) break;
      n++; prev = cur;
    end
    check("R2 period length", n, 20);

    // R6: shadowed channel 0 holds old values until the boundary after a request
    wr(6'd2, 8'h01); wr(6'd16, 8'd2); wr(6'd17, 8'd5);
    rd(6'd16, v); check("R6 active on-step before commit", v, 0);
    rd(6'd17, v); check("R6 active off-step before commit", v, 0);
    measure(0, 20, n); check("R6 output before request", n, 0);
    wait_start(); wr(6'd4, 8'h01);
    rd(6'd4, v); check("R8 pending reads 1", v, 1);
    wait_start();
    rd(6'd4, v);  check("R8 cleared after commit", v, 0);
    rd(6'd16, v); check("R6 on-step committed", v, 2);
    rd(6'd17, v); check("R6 off-step committed", v, 5);
    measure(0, 20, n); check("R6 output after commit", n, exp_high(2, 5, 9, 1));

    // R7: writes after the request wait for another request
    wr(6'd2, 8'h03);
    wait_start(); wr(6'd4, 8'h01); wr(6'd18, 8'd1); wr(6'd19, 8'd8);
    wait_start();
    rd(6'd4, v);  check("R7 request consumed", v, 0);
    rd(6'd18, v); check("R7 late write not committed", v, 0);
    measure(1, 20, n); check("R7 output unchanged", n, 0);
    wait_start(); wr(6'd4, 8'h01); wait_start();
    rd(6'd18, v); check("R7 on-step after second request", v, 1);
    rd(6'd19, v); check("R7 off-step after second request", v, 8);
    measure(1, 20, n); check("R7 output after second request", n, exp_high(1, 8, 9, 1));

    // R4: corners on direct channel 9
    wr(6'd3, 8'h03);
    wr(6'd34, 8'd4); wr(6'd35, 8'd4);
    measure(9, 20, n); check("R4 equal edges low", n, 0);
    wr(6'd34, 8'd0); wr(6'd35, 8'd10);
    measure(9, 20, n); check("R4 full duty", n, 20);
    wr(6'd34, 8'd7); wr(6'd35, 8'd2);
    measure(9, 20, n); check("R4 wrapping window", n, exp_high(7, 2, 9, 1));

    // R3: enable bit mapping across both registers
    for (int c = 0; c < 16; c++) begin
      wr(6'(16 + 2*c), 8'd0); wr(6'(17 + 2*c), 8'd1);
    end
    wr(6'd4, 8'h01); wait_start(); wait_start();
    wr(6'd2, 8'hA5); wr(6'd3, 8'h3D);
    rd(6'd2, v); check("R3 enable lo readback", v, 8'hA5);
    rd(6'd3, v); check("R3 enable hi readback", v, 8'h3D);
    for (int c = 0; c < 16; c++) cnt[c] = 0;
    repeat (20) begin
      @(negedge clk);
      for (int c = 0; c < 16; c++) cnt[c] += int'(pwm_out[c]);
    end
    for (int c = 0; c < 16; c++)
      check($sformatf("R3 channel %0d", c), cnt[c], ((32'h3DA5 >> c) & 1) ? 2 : 0);

    // R4/R2 random patterns on direct channels
    wr(6'd3, 8'hFF);
    for (int it = 0; it < 24; it++) begin
      int ch, p, s, on_s, off_s;
      ch = 9 + int'($urandom % 7); p = int'($urandom % 4); s = 1 + int'($urandom % 30);
      on_s = int'($urandom % (s + 2)); off_s = int'($urandom % (s + 2));
      wr(6'd0, 8'(p)); wr(6'd1, 8'(s));
      wr(6'(16 + 2*ch), 8'(on_s)); wr(6'(17 + 2*ch), 8'(off_s));
      wait_start(); wait_start();
      measure(ch, (s + 1) * (p + 1), n);
      check($sformatf("R4 random ch%0d on%0d off%0d last%0d pre%0d", ch, on_s, off_s, s, p),
            n, exp_high(on_s, off_s, s, p));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule